// File: doc/BRIEF.md
# Key-Protected System Control Register Bank

This block holds a bank of 32-bit system control words behind a simple word-addressed bus with one request per cycle. A one-bit lock word at offset 0x000 gates software writes to the low part of the map. Writing the unlock key to that word opens the window. Writing any other value closes it again. Outside the window, writes always land.

A few words have their own write policies. The boot strap word can be built up by OR-ing data into it. It can be trimmed by writing a bit mask to the revision word, which never changes itself. Status, scratch and counter words ignore writes. A pseudo-random word produces a new value on each read. A write-only wake-up word flags reads of it. Reset loads a default table chosen by a variant parameter, then takes the lock, revision and strap words from input ports.

Every misuse is reported by a one-cycle error pulse. Misuse means a locked write, a write to a read-only word, an out-of-range or misaligned access, or a read of the write-only word.

Top module: `sysctl_regbank`

## Requirements
- R1: A byte address maps to word index addr>>2. An access whose addr[1:0] is not 0, or whose index is 106 or more (beyond byte offset 0x1A4 in the 4 KiB space), raises the error pulse and changes nothing. Such a read returns 0.
- R2: A write to offset 0x000 stores 1 when the data equals UNLOCK_KEY (default 0x1688A8A8) and 0 otherwise. A read of 0x000 returns the stored value.
- R3: While offset 0x000 holds 0, writes to offsets 0x004 through 0x100 are dropped and raise the error pulse. Writes at 0x104 and above are accepted.
- R4: With NEW_VARIANT=1, a write to 0x070 ORs the data into the strap word. A write to 0x07C clears the strap bits that are set in the data, with no error. Offset 0x07C itself never changes.
- R5: With NEW_VARIANT=0, a write to 0x070 overwrites the strap word. A write to 0x07C raises the error pulse and changes nothing.
- R6: Writes to 0x014, 0x050–0x06C, 0x078, 0x0E0 and 0x0E4 are ignored and raise the error pulse.
- R7: A read of 0x078 returns the state of a 32-bit LFSR and then advances it. The LFSR resets to SEED (default 0xACE10001). One step is next = (s>>1) ^ (s[0] ? 0x80200003 : 0). Writes do not advance it.
- R8: Reset loads the variant defaults. These include 0x004=0xFFCFFEDC and 0x008=0xF3F40000. Offset 0x09C is 0x023FFFF3 when new and 0x003FFFF3 when old. Offset 0x024 is 0x93000400 when new and 0x00000291 when old. Offsets 0x0E4 and 0x1A4 are 0x000000FF and 0x00002402. The reset also loads 0x000 from key_rst_i, 0x070 from strap1_i, 0x0D0 from strap2_i and 0x07C from rev_i.
- R9: rsp_valid_o is high for exactly the cycle after a read request, with rsp_rdata_o holding the read data. It stays low after writes.
- R10: A read of the write-only word 0x0C0 returns its stored value and raises the error pulse.
- R11: err_o is high for exactly the cycle after an offending request. A legal access leaves it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strap1_i | input | 32 | Strap word loaded at reset |
| strap2_i | input | 32 | Second strap word loaded at reset |
| rev_i | input | 32 | Revision word loaded at reset |
| key_rst_i | input | 1 | Lock word value loaded at reset (1 = unlocked) |
| req_valid_i | input | 1 | Access request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 12 | Byte address |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Read data valid |
| rsp_rdata_o | output | 32 | Read data |
| err_o | output | 1 | One-cycle error pulse |

## Verification
The hardest state to reach from the ports is the strap word after a mix of set and clear operations. Both of those paths sit inside the locked window, so they can only be exercised after an unlock sequence. The stimulus first shows that writes are dropped while the bank is locked. It then sends the key, ORs bits into the strap word and clears a partly overlapping mask through the revision address. The expected result is computed from the reset strap value. A second instance built as the old variant starts unlocked, and is used to show that the strap write overwrites and the revision write is refused.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  localparam int unsigned IDX_KEY      = 0;
  localparam int unsigned IDX_FCNT_RES = 5;
  localparam int unsigned IDX_SCR_LO   = 20;
  localparam int unsigned IDX_SCR_HI   = 27;
  localparam int unsigned IDX_STRAP1   = 28;
  localparam int unsigned IDX_RNG      = 30;
  localparam int unsigned IDX_REV      = 31;
  localparam int unsigned IDX_WAKE_EN  = 48;
  localparam int unsigned IDX_STRAP2   = 52;
  localparam int unsigned IDX_CNT_LO   = 56;
  localparam int unsigned IDX_CNT_HI   = 57;
  localparam int unsigned IDX_OPEN     = 65;  // first index outside the guarded window

  typedef enum logic [2:0] {
    CLS_PLAIN,
    CLS_KEY,
    CLS_STRAP,
    CLS_REV,
    CLS_RO,
    CLS_RNG,
    CLS_WO
  } reg_cls_e;

  function automatic logic [31:0] reset_word(input int unsigned idx, input bit new_var);
    case (idx)
      1:       reset_word = 32'hFFCFFEDC;
      2:       reset_word = 32'hF3F40000;
      3:       reset_word = 32'h19FC3E8B;
      7:       reset_word = 32'h00026108;
      8:       reset_word = 32'h00030291;
      9:       reset_word = new_var ? 32'h93000400 : 32'h00000291;
      11:      reset_word = 32'h00000010;
      12, 13:  reset_word = 32'h20001A03;
      14:      reset_word = 32'h04000030;
      15:      reset_word = 32'h00000001;
      16:      reset_word = 32'h000000C0;
      19:      reset_word = 32'h00000023;
      29:      reset_word = 32'h0000000E;
      33:      reset_word = 32'h0000F000;
      34:      reset_word = new_var ? 32'h03000000 : 32'h01000000;
      35:      reset_word = new_var ? 32'h00000000 : 32'h000000FF;
      36:      reset_word = 32'h0000A000;
      39:      reset_word = new_var ? 32'h023FFFF3 : 32'h003FFFF3;
      41:      reset_word = 32'hFFFF0000;
      42:      reset_word = 32'h000FFFFF;
      56, 57:  reset_word = 32'h000000FF;
      65:      reset_word = 32'h80000000;
      68:      reset_word = 32'h1E600000;
      69:      reset_word = 32'hC0000000;
      88:      reset_word = 32'h00001903;
      96:      reset_word = 32'h0000007B;
      105:     reset_word = 32'h00002402;
      default: reset_word = 32'h0;
    endcase
  endfunction

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned NUM_REGS = 106,
  localparam int unsigned WORD_W  = ADDR_W - 2,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic              hit_o,
  output logic              guarded_o,
  output reg_cls_e          cls_o
);

  logic [WORD_W-1:0] word;
  assign word  = addr_i[ADDR_W-1:2];
  assign idx_o = word[IDX_W-1:0];
  assign hit_o = (addr_i[1:0] == 2'b00) && (word < WORD_W'(NUM_REGS));

  assign guarded_o = (word != '0) && (word < WORD_W'(IDX_OPEN));

  always_comb begin
    if (word == WORD_W'(IDX_KEY))                                     cls_o = CLS_KEY;
    else if (word == WORD_W'(IDX_STRAP1))                             cls_o = CLS_STRAP;
    else if (word == WORD_W'(IDX_REV))                                cls_o = CLS_REV;
    else if (word == WORD_W'(IDX_RNG))                                cls_o = CLS_RNG;
    else if (word == WORD_W'(IDX_WAKE_EN))                            cls_o = CLS_WO;
    else if ((word == WORD_W'(IDX_FCNT_RES)) ||
             (word >= WORD_W'(IDX_SCR_LO) && word <= WORD_W'(IDX_SCR_HI)) ||
             (word == WORD_W'(IDX_CNT_LO)) || (word == WORD_W'(IDX_CNT_HI))) cls_o = CLS_RO;
    else                                                              cls_o = CLS_PLAIN;
  end

  always_comb begin
    if (hit_o) a_hit_range_r1: assert (int'(idx_o) < NUM_REGS);
  end

endmodule

// File: rtl/sysctl_lfsr.sv
module sysctl_lfsr #(
  parameter int unsigned  W    = 32,
  parameter logic [W-1:0] TAPS = 32'h80200003,
  parameter logic [W-1:0] SEED = 32'hACE10001
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  output logic [W-1:0] state_o
);

  logic [W-1:0] state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_q <= SEED;
    else if (step_i) state_q <= {1'b0, state_q[W-1:1]} ^ (state_q[0] ? TAPS : '0);
  end

  assign state_o = state_q;

  p_lfsr_live_r7: assert property (@(posedge clk_i) disable iff (!rst_ni) state_q != '0);
  p_lfsr_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
                                   !step_i |=> $stable(state_q));

endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
  import sysctl_pkg::*;
#(
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned NUM_REGS    = 106,
  parameter logic [31:0] UNLOCK_KEY  = 32'h1688A8A8,
  parameter logic [31:0] LFSR_SEED   = 32'hACE10001,
  parameter bit          NEW_VARIANT = 1'b1,
  localparam int unsigned IDX_W      = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] strap1_i,
  input  logic [DATA_W-1:0] strap2_i,
  input  logic [DATA_W-1:0] rev_i,
  input  logic              key_rst_i,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              err_o
);

  logic [DATA_W-1:0] regs_q [NUM_REGS];
  logic [IDX_W-1:0]  idx;
  logic              hit, guarded, locked, blocked;
  logic              wr_req, rd_req, wr_ok, rng_step, err_d;
  logic [DATA_W-1:0] rdata_d, rng_word;
  reg_cls_e          cls;

  sysctl_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_decode (
    .addr_i   (req_addr_i),
    .idx_o    (idx),
    .hit_o    (hit),
    .guarded_o(guarded),
    .cls_o    (cls)
  );

  sysctl_lfsr #(.W(DATA_W), .TAPS(32'h80200003), .SEED(LFSR_SEED)) u_lfsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (rng_step),
    .state_o(rng_word)
  );

  assign locked   = (regs_q[IDX_KEY] == '0);
  assign wr_req   = req_valid_i && req_write_i;
  assign rd_req   = req_valid_i && !req_write_i;
  assign blocked  = guarded && locked;
  assign wr_ok    = wr_req && hit && !blocked;
  assign rng_step = rd_req && hit && (cls == CLS_RNG);

  always_comb begin
    err_d = 1'b0;
    if (req_valid_i && !hit) err_d = 1'b1;
    else if (wr_req) begin
      if (blocked)                              err_d = 1'b1;
      else if (cls == CLS_RO || cls == CLS_RNG) err_d = 1'b1;
      else if (cls == CLS_REV && !NEW_VARIANT)  err_d = 1'b1;
    end else if (rd_req && cls == CLS_WO)       err_d = 1'b1;
  end

  always_comb begin
    rdata_d = '0;
    if (rd_req && hit) rdata_d = (cls == CLS_RNG) ? rng_word : regs_q[idx];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= reset_word(i, NEW_VARIANT);
      regs_q[IDX_KEY]    <= {{(DATA_W-1){1'b0}}, key_rst_i};
      regs_q[IDX_STRAP1] <= strap1_i;
      regs_q[IDX_STRAP2] <= strap2_i;
      regs_q[IDX_REV]    <= rev_i;
    end else if (wr_ok) begin
      case (cls)
        CLS_KEY:   regs_q[IDX_KEY] <= {{(DATA_W-1){1'b0}}, (req_wdata_i == UNLOCK_KEY)};
        CLS_STRAP: regs_q[IDX_STRAP1] <= NEW_VARIANT ? (regs_q[IDX_STRAP1] | req_wdata_i)
                                                     : req_wdata_i;
        CLS_REV:   if (NEW_VARIANT) regs_q[IDX_STRAP1] <= regs_q[IDX_STRAP1] & ~req_wdata_i;
        CLS_RO, CLS_RNG: ;
        default:   regs_q[idx] <= req_wdata_i;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
      err_o       <= 1'b0;
    end else begin
      rsp_valid_o <= rd_req;
      rsp_rdata_o <= rdata_d;
      err_o       <= err_d;
    end
  end

  p_oob_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !hit) |=> (err_o && rsp_rdata_o == '0));

  p_unlock_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req && req_addr_i == '0 && req_wdata_i == UNLOCK_KEY) |=> (regs_q[IDX_KEY] == 1));

  p_lock_any_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req && req_addr_i == '0 && req_wdata_i != UNLOCK_KEY) |=> (regs_q[IDX_KEY] == 0));

  p_locked_strap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req && locked && req_addr_i == ADDR_W'(IDX_STRAP1 * 4)) |=> $stable(regs_q[IDX_STRAP1]));

  p_rev_const_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> $stable(regs_q[IDX_REV]));

  generate
    if (NEW_VARIANT) begin : g_new_chk
      p_rev_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_req && !locked && req_addr_i == ADDR_W'(IDX_REV * 4))
        |=> (regs_q[IDX_STRAP1] == ($past(regs_q[IDX_STRAP1]) & ~$past(req_wdata_i))));
    end else begin : g_old_chk
      p_rev_refused_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_req && req_addr_i == ADDR_W'(IDX_REV * 4)) |=> (err_o && $stable(regs_q[IDX_STRAP1])));
    end
  endgenerate

  p_rsp_follows_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req |=> rsp_valid_o);

  p_rsp_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req |=> !rsp_valid_o);

  p_wo_read_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req && req_addr_i == ADDR_W'(IDX_WAKE_EN * 4)) |=> err_o);

  p_err_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !err_o);

endmodule

// File: tb/sysctl_regbank_tb.sv
module sysctl_regbank_tb;

  localparam time CLK_PERIOD = 10ns;
  localparam logic [31:0] STRAP1 = 32'h00000F00;
  localparam logic [31:0] STRAP2 = 32'h12345678;
  localparam logic [31:0] REV    = 32'h04030303;
  localparam logic [31:0] KEY    = 32'h1688A8A8;
  localparam logic [31:0] SEED   = 32'hACE10001;

  typedef struct packed {
    logic        we;
    logic [11:0] addr;
    logic [31:0] wd;
    logic [31:0] rd;
    logic        er;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 36;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 12'h000, 32'h0,        32'h00000000, 1'b0, 8'd8},  // R8 key from port
    '{1'b1, 12'h008, 32'h0000DEAD, 32'h0,        1'b1, 8'd3},  // R3 locked
    '{1'b0, 12'h008, 32'h0,        32'hF3F40000, 1'b0, 8'd3},  // R3 dropped
    '{1'b1, 12'h104, 32'h11112222, 32'h0,        1'b0, 8'd3},  // R3 open region
    '{1'b0, 12'h104, 32'h0,        32'h11112222, 1'b0, 8'd3},
    '{1'b1, 12'h100, 32'h00000005, 32'h0,        1'b1, 8'd3},  // R3 top edge
    '{1'b0, 12'h100, 32'h0,        32'h00000000, 1'b0, 8'd3},
    '{1'b1, 12'h000, 32'h12345678, 32'h0,        1'b0, 8'd2},  // R2 wrong key
    '{1'b0, 12'h000, 32'h0,        32'h00000000, 1'b0, 8'd2},
    '{1'b1, 12'h000, KEY,          32'h0,        1'b0, 8'd2},  // R2 unlock
    '{1'b0, 12'h000, 32'h0,        32'h00000001, 1'b0, 8'd2},
    '{1'b1, 12'h008, 32'h0000ABCD, 32'h0,        1'b0, 8'd3},
    '{1'b0, 12'h008, 32'h0,        32'h0000ABCD, 1'b0, 8'd3},
    '{1'b1, 12'h070, 32'h000000F1, 32'h0,        1'b0, 8'd4},  // R4 OR in
    '{1'b0, 12'h070, 32'h0,        32'h00000FF1, 1'b0, 8'd4},
    '{1'b1, 12'h07C, 32'h00000F01, 32'h0,        1'b0, 8'd4},  // R4 clear mask
    '{1'b0, 12'h070, 32'h0,        32'h000000F0, 1'b0, 8'd4},
    '{1'b0, 12'h07C, 32'h0,        REV,          1'b0, 8'd4},
    '{1'b1, 12'h014, 32'h0000FFFF, 32'h0,        1'b1, 8'd6},  // R6
    '{1'b0, 12'h014, 32'h0,        32'h00000000, 1'b0, 8'd6},
    '{1'b1, 12'h05C, 32'h00000001, 32'h0,        1'b1, 8'd6},
    '{1'b0, 12'h05C, 32'h0,        32'h00000000, 1'b0, 8'd6},
    '{1'b1, 12'h0E4, 32'h00000005, 32'h0,        1'b1, 8'd6},
    '{1'b0, 12'h0E4, 32'h0,        32'h000000FF, 1'b0, 8'd6},
    '{1'b1, 12'h0C0, 32'h00000033, 32'h0,        1'b0, 8'd10}, // R10
    '{1'b0, 12'h0C0, 32'h0,        32'h00000033, 1'b1, 8'd10},
    '{1'b1, 12'h1A8, 32'h00000001, 32'h0,        1'b1, 8'd1},  // R1 past end
    '{1'b0, 12'h1A8, 32'h0,        32'h00000000, 1'b1, 8'd1},
    '{1'b0, 12'h009, 32'h0,        32'h00000000, 1'b1, 8'd1},  // R1 misaligned
    '{1'b0, 12'hFFC, 32'h0,        32'h00000000, 1'b1, 8'd1},
    '{1'b0, 12'h1A4, 32'h0,        32'h00002402, 1'b0, 8'd8},  // R8 last word
    '{1'b0, 12'h09C, 32'h0,        32'h023FFFF3, 1'b0, 8'd8},
    '{1'b0, 12'h024, 32'h0,        32'h93000400, 1'b0, 8'd8},
    '{1'b0, 12'h0D0, 32'h0,        STRAP2,       1'b0, 8'd8},
    '{1'b0, 12'h004, 32'h0,        32'hFFCFFEDC, 1'b0, 8'd8},
    '{1'b1, 12'h078, 32'h0000BEEF, 32'h0,        1'b1, 8'd6}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid [2];
  logic        write [2];
  logic [11:0] addr  [2];
  logic [31:0] wdata [2];
  logic        rsp   [2];
  logic [31:0] rdata [2];
  logic        err   [2];
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sysctl_regbank #(.NEW_VARIANT(1'b1)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .strap1_i(STRAP1), .strap2_i(STRAP2), .rev_i(REV),
    .key_rst_i(1'b0), .req_valid_i(valid[0]), .req_write_i(write[0]), .req_addr_i(addr[0]),
    .req_wdata_i(wdata[0]), .rsp_valid_o(rsp[0]), .rsp_rdata_o(rdata[0]), .err_o(err[0]));

  sysctl_regbank #(.NEW_VARIANT(1'b0)) u_dut_old (
    .clk_i(clk), .rst_ni(rst_n), .strap1_i(STRAP1), .strap2_i(STRAP2), .rev_i(REV),
    .key_rst_i(1'b1), .req_valid_i(valid[1]), .req_write_i(write[1]), .req_addr_i(addr[1]),
    .req_wdata_i(wdata[1]), .rsp_valid_o(rsp[1]), .rsp_rdata_o(rdata[1]), .err_o(err[1]));

  function automatic logic [31:0] lfsr_next(input logic [31:0] s);
    return (s >> 1) ^ (s[0] ? 32'h80200003 : 32'h0);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input int d, input logic we, input logic [11:0] a, input logic [31:0] wd,
                     output logic [31:0] rd, output logic er, output logic rv);
    @(negedge clk);
    valid[d] = 1'b1; write[d] = we; addr[d] = a; wdata[d] = wd;
    @(negedge clk);
    valid[d] = 1'b0; write[d] = 1'b0;
    rd = rdata[d]; er = err[d]; rv = rsp[d];
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic        er, rv;
    logic [31:0] model;
    for (int d = 0; d < 2; d++) begin
      valid[d] = 1'b0; write[d] = 1'b0; addr[d] = '0; wdata[d] = '0;
    end
    repeat (3) @(negedge clk);
    // R9 R11 quiet outputs in reset
    chk("R9 rsp in reset", {31'b0, rsp[0]}, 32'h0);
    chk("R11 err in reset", {31'b0, err[0]}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      acc(0, VECS[i].we, VECS[i].addr, VECS[i].wd, rd, er, rv);
      if (!VECS[i].we) chk($sformatf("R%0d read %h", VECS[i].req, VECS[i].addr), rd, VECS[i].rd);
      chk($sformatf("R%0d err %h", VECS[i].req, VECS[i].addr), {31'b0, er}, {31'b0, VECS[i].er});
      chk($sformatf("R9 rsp_valid %h", VECS[i].addr), {31'b0, rv}, {31'b0, !VECS[i].we});
    end

    // R11 pulse lasts one cycle
    acc(0, 1'b1, 12'h014, 32'h1, rd, er, rv);
    chk("R11 err pulse", {31'b0, er}, 32'h1);
    @(negedge clk);
    chk("R11 err cleared", {31'b0, err[0]}, 32'h0);

    // R7 random word sequence, unaffected by the earlier write to it
    model = SEED;
    for (int k = 0; k < 4; k++) begin
      acc(0, 1'b0, 12'h078, 32'h0, rd, er, rv);
      chk($sformatf("R7 rng read %0d", k), rd, model);
      model = lfsr_next(model);
    end

    // R5 old variant, unlocked at reset
    acc(1, 1'b0, 12'h000, 32'h0, rd, er, rv);
    chk("R8 old key from port", rd, 32'h1);
    acc(1, 1'b0, 12'h09C, 32'h0, rd, er, rv);
    chk("R8 old wdt default", rd, 32'h003FFFF3);
    acc(1, 1'b0, 12'h024, 32'h0, rd, er, rv);
    chk("R8 old pll default", rd, 32'h00000291);
    acc(1, 1'b0, 12'h070, 32'h0, rd, er, rv);
    chk("R8 old strap from port", rd, STRAP1);
    acc(1, 1'b1, 12'h070, 32'h000000F1, rd, er, rv);
    chk("R5 strap write err", {31'b0, er}, 32'h0);
    acc(1, 1'b0, 12'h070, 32'h0, rd, er, rv);
    chk("R5 strap overwrite", rd, 32'h000000F1);
    acc(1, 1'b1, 12'h07C, 32'h000000FF, rd, er, rv);
    chk("R5 rev write err", {31'b0, er}, 32'h1);
    acc(1, 1'b0, 12'h070, 32'h0, rd, er, rv);
    chk("R5 strap kept", rd, 32'h000000F1);
    acc(1, 1'b0, 12'h07C, 32'h0, rd, er, rv);
    chk("R5 rev kept", rd, REV);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule